// File: doc/BRIEF.md
# Accuracy-Configurable Carry-Select Adder

This block is a purely combinational N-bit adder (8 bits by default) that a caller can switch between an exact and an approximate mode on every operation. The operands are cut into segments of a fixed length. Each segment works out two candidate results at the same time, one for an incoming carry of 0 and one for an incoming carry of 1. A multiplexer then keeps the one that matches the carry actually presented to that segment.

In exact mode, the carry into every segment is the true carry out of the segment below it, so the sum matches ordinary binary addition. In approximate mode, the carry into each segment above the lowest one is only a guess: the AND of the two operand bits at the top position of the segment below. This removes the long chain of selects from the critical path. The price is a wrong result whenever a carry ripples into that top bit without being generated there. No logic detects or corrects such errors. The lowest segment always uses the external carry-in.

Top module: `aca_adder`

## Requirements
- R1: With exact_mode = 1, {carry_out, sum_out} equals a_in + b_in + carry_in for every input combination.
- R2: In either mode, sum_out bits L-1..0 equal the low L bits of a_in + b_in + carry_in.
- R3: With exact_mode = 0, the carry entering segment k > 0 (bits k*L and up) is a_in[k*L-1] AND b_in[k*L-1]. That segment's sum slice is its operand slices plus that carry, and carry_out is the carry out of the top segment when the top segment is fed this way.
- R4: Inside each segment, the result precomputed for carry-in 1 equals the result for carry-in 0 plus one. The real incoming carry selects between them, so an exact-mode carry crossing a boundary moves the upper segment to the +1 result.
- R5: With exact_mode = 0, carry_in = 0 and a_in AND b_in all zero, the outputs equal the exact sum.
- R6: Exact mode, a_in = 10010101, b_in = 01100010, carry_in = 0 gives sum_out = 11110111 and carry_out = 0.
- R7: Exact mode, a_in = 10111010, b_in = 10010001, carry_in = 1 gives sum_out = 01001100 and carry_out = 1.
- R8: In approximate mode, a carry that propagates into a segment's top bit without being generated there is lost. a_in = 00001111, b_in = 00000001, carry_in = 0 gives sum_out = 00000000 and carry_out = 0, where the exact sum is 00010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| carry_in | input | 1 | Carry into the lowest bit |
| exact_mode | input | 1 | 1 selects exact carries between segments, 0 selects predicted carries |
| sum_out | output | N | Sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is an approximate result that is wrong. That needs an operand pattern in which a carry is propagated, but not generated, at a segment's top bit, and in which that lost carry changes the upper segment. Only a thin slice of random pairs does this. The stimulus therefore covers both modes over the full 17-bit input space against a bench model that applies the same boundary guess, and adds a directed pattern that forces a lost carry across the boundary. The sweep also counts how many approximate results differ from the true sum.

// File: rtl/aca_pkg.sv
`timescale 1ns/1ps
package aca_pkg;

  // Width of segment k for an n-bit adder split into l-bit pieces.
  function automatic int seg_width(input int k, input int n, input int l);
    return ((k + 1) * l <= n) ? l : (n - k * l);
  endfunction

  // Per-bit precompute under an assumed incoming carry: returns {carry, sum}.
  function automatic logic [1:0] pre_bit(input logic a, input logic b, input logic assumed_c);
    logic [1:0] r;
    if (assumed_c) r = {a | b, ~(a ^ b)};
    else           r = {a & b, a ^ b};
    return r;
  endfunction

  // Full-adder step returning {carry, sum}.
  function automatic logic [1:0] fa_bit(input logic a, input logic b, input logic c);
    return {(a & b) | (c & (a ^ b)), a ^ b ^ c};
  endfunction

  // Boundary carry guess: the generate term of a segment's top bit.
  function automatic logic guess_carry(input logic a_top, input logic b_top);
    return a_top & b_top;
  endfunction

endpackage

// File: rtl/aca_seg.sv
`timescale 1ns/1ps
module aca_seg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s0,
  output logic [W-1:0] s1,
  output logic         c0,
  output logic         c1
);
  import aca_pkg::*;

  logic [W:1] k0;
  logic [W:1] k1;

  always_comb begin
    {k0[1], s0[0]} = pre_bit(a[0], b[0], 1'b0);
    {k1[1], s1[0]} = pre_bit(a[0], b[0], 1'b1);
    for (int i = 1; i < W; i++) begin
      {k0[i+1], s0[i]} = fa_bit(a[i], b[i], k0[i]);
      {k1[i+1], s1[i]} = fa_bit(a[i], b[i], k1[i]);
    end
  end

  assign c0 = k0[W];
  assign c1 = k1[W];
endmodule

// File: rtl/aca_link.sv
`timescale 1ns/1ps
module aca_link (
  input  logic exact_mode,
  input  logic true_c,
  input  logic a_top,
  input  logic b_top,
  output logic c_next
);
  import aca_pkg::*;
  assign c_next = exact_mode ? true_c : guess_carry(a_top, b_top);
endmodule

// File: rtl/aca_sel.sv
`timescale 1ns/1ps
module aca_sel #(
  parameter int W = 4
) (
  input  logic [W-1:0] s0,
  input  logic [W-1:0] s1,
  input  logic         c0,
  input  logic         c1,
  input  logic         csel,
  output logic [W-1:0] sum,
  output logic         cout
);
  assign sum  = csel ? s1 : s0;
  assign cout = csel ? c1 : c0;
endmodule

// File: rtl/aca_adder.sv
`timescale 1ns/1ps
module aca_adder #(
  parameter int N = 8,
  parameter int L = 4
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         carry_in,
  input  logic         exact_mode,
  output logic [N-1:0] sum_out,
  output logic         carry_out
);
  import aca_pkg::*;

  localparam int K = (N + L - 1) / L;

  // Precomputed segment results, brought out for the checker.
  logic [N-1:0] pre_s0;
  logic [N-1:0] pre_s1;
  logic [K-1:0] seg_c0;
  logic [K-1:0] seg_c1;

  for (genvar k = 0; k < K; k++) begin : g_seg
    localparam int LO = k * L;
    localparam int W  = seg_width(k, N, L);
    logic cin_k;
    logic cout_k;

    aca_seg #(.W(W)) u_seg (
      .a (a_in[LO +: W]),
      .b (b_in[LO +: W]),
      .s0(pre_s0[LO +: W]),
      .s1(pre_s1[LO +: W]),
      .c0(seg_c0[k]),
      .c1(seg_c1[k])
    );

    if (k == 0) begin : g_first
      assign cin_k = carry_in;
    end else begin : g_link
      aca_link u_link (
        .exact_mode(exact_mode),
        .true_c    (g_seg[k-1].cout_k),
        .a_top     (a_in[LO-1]),
        .b_top     (b_in[LO-1]),
        .c_next    (cin_k)
      );
    end

    aca_sel #(.W(W)) u_sel (
      .s0  (pre_s0[LO +: W]),
      .s1  (pre_s1[LO +: W]),
      .c0  (seg_c0[k]),
      .c1  (seg_c1[k]),
      .csel(cin_k),
      .sum (sum_out[LO +: W]),
      .cout(cout_k)
    );
  end

  assign carry_out = g_seg[K-1].cout_k;
endmodule

// File: rtl/aca_adder_chk.sv
`timescale 1ns/1ps
module aca_adder_chk #(
  parameter int N = 8,
  parameter int L = 4
) (
  input logic [N-1:0] a_in,
  input logic [N-1:0] b_in,
  input logic         carry_in,
  input logic         exact_mode,
  input logic [N-1:0] sum_out,
  input logic         carry_out,
  input logic [N-1:0] pre_s0,
  input logic [N-1:0] pre_s1,
  input logic [(N+L-1)/L-1:0] seg_c0,
  input logic [(N+L-1)/L-1:0] seg_c1
);
  import aca_pkg::*;
  localparam int K  = (N + L - 1) / L;
  localparam int W0 = seg_width(0, N, L);

  logic [N:0]  exact_full;
  logic [W0:0] low_full;
  assign exact_full = {1'b0, a_in} + {1'b0, b_in} + {{N{1'b0}}, carry_in};
  assign low_full   = {1'b0, a_in[W0-1:0]} + {1'b0, b_in[W0-1:0]} + {{W0{1'b0}}, carry_in};

  always_comb begin
    // R1
    exact_sum_chk: assert (!exact_mode || ({carry_out, sum_out} == exact_full))
      else $error("exact mode sum differs from a+b+cin");
    // R2
    low_seg_chk: assert (sum_out[W0-1:0] == low_full[W0-1:0])
      else $error("lowest segment differs from exact low bits");
    // R5
    no_gen_chk: assert (exact_mode || carry_in || ((a_in & b_in) != '0) ||
                        ({carry_out, sum_out} == exact_full))
      else $error("approximate mode wrong with no generate bits");
  end

  for (genvar k = 0; k < K; k++) begin : g_chk
    localparam int LO = k * L;
    localparam int W  = seg_width(k, N, L);
    logic [W:0] r0;
    logic [W:0] r1;
    assign r0 = {seg_c0[k], pre_s0[LO +: W]};
    assign r1 = {seg_c1[k], pre_s1[LO +: W]};

    always_comb begin
      // R4
      pair_step_chk: assert (r1 == ((r0 + {{W{1'b0}}, 1'b1}) & {(W+1){1'b1}}))
        else $error("segment cin1 result is not cin0 result plus one");
    end

    if (k > 0) begin : g_apx
      logic [W:0] guess_full;
      assign guess_full = {1'b0, a_in[LO +: W]} + {1'b0, b_in[LO +: W]} +
                          {{W{1'b0}}, a_in[LO-1] & b_in[LO-1]};
      always_comb begin
        // R3
        apx_seg_chk: assert (exact_mode || (sum_out[LO +: W] == guess_full[W-1:0]))
          else $error("approximate segment sum does not use predicted carry");
        if (k == K - 1) begin
          // R3
          apx_cout_chk: assert (exact_mode || (carry_out == guess_full[W]))
            else $error("approximate carry out does not use predicted carry");
        end
      end
    end
  end
endmodule

bind aca_adder aca_adder_chk #(.N(N), .L(L)) u_chk (
  .a_in      (a_in),
  .b_in      (b_in),
  .carry_in  (carry_in),
  .exact_mode(exact_mode),
  .sum_out   (sum_out),
  .carry_out (carry_out),
  .pre_s0    (pre_s0),
  .pre_s1    (pre_s1),
  .seg_c0    (seg_c0),
  .seg_c1    (seg_c1)
);

// File: tb/aca_adder_bench.sv
`timescale 1ns/1ps
module aca_adder_bench;
  localparam int N = 8;
  localparam int L = 4;
  localparam int K = (N + L - 1) / L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] a_in, b_in, sum_out;
  logic carry_in, exact_mode, carry_out;

  int n_chk = 0;
  int n_bad = 0;
  int n_apx_diff = 0;
  bit done = 1'b0;

  aca_adder #(.N(N), .L(L)) u_aca_adder (
    .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .exact_mode(exact_mode),
    .sum_out(sum_out), .carry_out(carry_out)
  );

  // Bench model: segment-wise addition with either true or guessed boundary carries.
  function automatic logic [N:0] model(input logic [N-1:0] a, input logic [N-1:0] b,
                                       input logic ci, input logic ex);
    int carry = ci;
    int s = 0;
    for (int k = 0; k < K; k++) begin
      int lo = k * L;
      int w = ((k + 1) * L <= N) ? L : N - lo;
      int mask = (1 << w) - 1;
      int cin_k;
      int r;
      if (k == 0) cin_k = ci;
      else if (ex) cin_k = carry;
      else cin_k = a[lo-1] & b[lo-1];
      r = ((int'(a) >> lo) & mask) + ((int'(b) >> lo) & mask) + cin_k;
      s = s | ((r & mask) << lo);
      carry = (r >> w) & 1;
    end
    return {carry[0], s[N-1:0]};
  endfunction

  task automatic check(input string req, input logic [N:0] exp_v);
    n_chk++;
    if ({carry_out, sum_out} !== exp_v) begin
      n_bad++;
      $display("FAIL %s a=%b b=%b cin=%b mode=%b got=%b expected=%b",
               req, a_in, b_in, carry_in, exact_mode, {carry_out, sum_out}, exp_v);
    end
  endtask

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b, input logic ci, input logic ex);
    a_in = a; b_in = b; carry_in = ci; exact_mode = ex;
    #1;
  endtask

  task automatic t_idle;
    apply('0, '0, 1'b0, 1'b1);
    check("R1 zero inputs", '0);
  endtask

  task automatic t_examples;
    apply(8'b10010101, 8'b01100010, 1'b0, 1'b1);
    check("R6", 9'b0_11110111);
    apply(8'b10111010, 8'b10010001, 1'b1, 1'b1);
    check("R7", 9'b1_01001100);
  endtask

  task automatic t_boundary;
    // R4: carry crossing the boundary selects the +1 result of the upper segment
    apply(8'h0F, 8'h00, 1'b0, 1'b1);
    check("R4 no carry", 9'h00F);
    apply(8'h0F, 8'h00, 1'b1, 1'b1);
    check("R4 carry across", 9'h010);
    // R8: propagated-only carry at top bit of segment 0 is lost
    apply(8'b00001111, 8'b00000001, 1'b0, 1'b0);
    check("R8 lost carry", 9'b0_00000000);
    // R3: generated carry at top bit is predicted correctly
    apply(8'h08, 8'h08, 1'b0, 1'b0);
    check("R3 generated carry", 9'h010);
    apply(8'hF8, 8'h08, 1'b0, 1'b0);
    check("R3 carry out", 9'h100);
    // R5: no generate bits, cin 0
    apply(8'hA5, 8'h5A, 1'b0, 1'b0);
    check("R5 no generate", 9'h0FF);
  endtask

  task automatic t_exact_sweep;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) begin
          apply(a[N-1:0], b[N-1:0], c[0], 1'b1);
          check("R1", 9'(a + b + c));
        end
  endtask

  task automatic t_apx_sweep;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) begin
          logic [N:0] m;
          apply(a[N-1:0], b[N-1:0], c[0], 1'b0);
          m = model(a[N-1:0], b[N-1:0], c[0], 1'b0);
          check("R3", m);
          n_chk++;
          if (sum_out[L-1:0] !== 4'(a + b + c)) begin
            n_bad++;
            $display("FAIL R2 a=%0d b=%0d got=%h expected=%h", a, b, sum_out[L-1:0], 4'(a + b + c));
          end
          if (m != 9'(a + b + c)) n_apx_diff++;
        end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    a_in = '0; b_in = '0; carry_in = 1'b0; exact_mode = 1'b1;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_idle;
    t_examples;
    t_boundary;
    t_exact_sweep;
    t_apx_sweep;
    $display("approximate mode differs from exact in %0d of %0d cases", n_apx_diff, 2 * 256 * 256);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule